// File: doc/BRIEF.md
# Counted-Assertion Interrupt Delivery Engine

This block decides when each interrupt pin of an interrupt router produces an outgoing interrupt message. Every pin keeps a signed assertion count instead of a single level bit, so several sources can share a pin: only the step of that count from zero to one triggers a delivery attempt. The block also holds the routing entry of every pin: vector, delivery mode, destination mode, destination, trigger kind and mask. It keeps the remote-IRR flag that holds off a level-triggered pin until the matching end-of-interrupt arrives.

All work enters through one command port: assert, deassert, pulse, end-of-interrupt and entry write. A pin command is handled in the cycle it is accepted. An end-of-interrupt starts a sequencer that visits one pin per cycle and may send again any pin that is still asserted. Outgoing messages leave on a valid/ready handshake. While a message waits, or while a scan runs, the block raises `busy` and accepts no command. A write that changes an entry in a way that affects trigger-mode bookkeeping produces a one-cycle notice, so that receivers can rebuild their trigger-mode state.

Top module: `pin_intr_engine`

## Requirements
- R1: Opcode 0 (assert) adds one to the pin's count and opcode 1 (deassert) subtracts one. Opcode 2 (pulse) adds one and then subtracts one within the same command, so the count ends where it started.
- R2: A delivery attempt is made only when a command moves the count from exactly 0 to 1: an assert at count 0, or a pulse at count 0. No other count change produces a message.
- R3: When a command drives the count below zero at either step, `cntErr` is high for one cycle and no message is produced. This covers a deassert at count 0 and a pulse at a negative count.
- R4: Entry bit 16 is the mask. After reset every entry holds only the mask bit. A delivery attempt on a masked entry sends nothing and leaves remote IRR unchanged, but the count still changes.
- R5: A message takes its vector from entry bits 7:0, its delivery mode from bits 10:8, its logical-destination flag from bit 11, its destination from bits 63:56 and its level flag from bit 15. Sending from an entry whose bit 15 is set also sets that pin's bit in `irrBits`.
- R6: Opcode 4 writes `cmdData` into the entry. Bits 12 and 14 of the data are ignored, and the write never changes remote IRR. After the write, the pin is sent if it is unmasked, its remote IRR is clear and its count is above zero.
- R7: `tmrUpdate` is high for one cycle after a write that changes any entry bit other than bit 16 (mask) and bit 13 (polarity).
- R8: Opcode 3 (end-of-interrupt, vector in `cmdData[7:0]`) visits the pins in ascending order, one per cycle, with `busy` high throughout. Each visited pin whose remote IRR is set and whose vector matches has its remote IRR cleared, and it is sent again if its count is above zero.
- R9: A pin command naming an index of `NUM_PINS` or more raises `pinErr` for one cycle and changes no count, entry or remote IRR.
- R10: A pending message keeps `msgValid` and all its fields unchanged until `msgReady` is seen. While a message is pending, `busy` stays high and no command is accepted.
- R11: Message, `tmrUpdate`, `pinErr` and `cntErr` all appear in the cycle after the clock edge that accepts the command (`cmdValid` high, `busy` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | Command opcode (0 assert, 1 deassert, 2 pulse, 3 end-of-interrupt, 4 entry write) |
| cmdPin | input | PIN_W | Pin index for pin commands |
| cmdData | input | 64 | Entry value for writes; vector in bits 7:0 for end-of-interrupt |
| busy | output | 1 | Command not accepted this cycle |
| msgValid | output | 1 | Interrupt message pending |
| msgReady | input | 1 | Receiver takes the pending message |
| msgVector | output | 8 | Message vector |
| msgDelMode | output | 3 | Message delivery mode |
| msgLogical | output | 1 | Destination is logical (1) or physical (0) |
| msgDest | output | 8 | Destination ID |
| msgLevel | output | 1 | Message comes from a level-triggered entry |
| tmrUpdate | output | 1 | One-cycle trigger-mode-change notice |
| irrBits | output | NUM_PINS | Remote-IRR flag of each pin |
| pinErr | output | 1 | One-cycle flag for an out-of-range pin command |
| cntErr | output | 1 | One-cycle flag for a count driven negative |

## Verification
The bench builds the block with `NUM_PINS` = 8 and `CNT_W` = 4. With eight pins, a full end-of-interrupt scan takes only a few cycles, so the bench can observe the whole scan, including a re-send in the middle of it and the stall while that message waits. The 4-bit pin field can carry indices 8 and 15, which exercise the out-of-range rejection. With the narrow count, negative counts arise after only a few commands.

// File: rtl/pin_intr_engine_pkg.sv
package pin_intr_engine_pkg;

  typedef enum logic [2:0] {
    OP_ASSERT   = 3'd0,
    OP_DEASSERT = 3'd1,
    OP_PULSE    = 3'd2,
    OP_EOI      = 3'd3,
    OP_WRITE    = 3'd4
  } cmd_op_e;

  // Entry field positions the message builder and the write filter decode.
  localparam int ENT_W       = 64;
  localparam int DMODE_LSB   = 8;
  localparam int LOGICAL_BIT = 11;
  localparam int STATUS_BIT  = 12;
  localparam int POL_BIT     = 13;
  localparam int IRR_BIT     = 14;
  localparam int LEVEL_BIT   = 15;
  localparam int MASK_BIT    = 16;
  localparam int DEST_LSB    = 56;

  localparam logic [ENT_W-1:0] RO_BITS    = (64'd1 << IRR_BIT) | (64'd1 << STATUS_BIT);
  localparam logic [ENT_W-1:0] NOTMR_BITS = (64'd1 << MASK_BIT) | (64'd1 << POL_BIT);
  localparam logic [ENT_W-1:0] RESET_ENT  = 64'd1 << MASK_BIT;

  // Strobes from control to datapath for one cycle of work.
  typedef struct packed {
    logic    pinCmd;    // accepted in-range pin command
    cmd_op_e op;
    logic    scanStep;  // end-of-interrupt visit of one pin
    logic    badPin;    // accepted pin command with out-of-range index
    logic [7:0] eoiVec;
  } strobe_t;

endpackage

// File: rtl/pin_intr_engine_ctrl.sv
module pin_intr_engine_ctrl
  import pin_intr_engine_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = $clog2(NUM_PINS) + 1,
  localparam int PIX_W   = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [PIN_W-1:0] cmdPin,
  input  logic [7:0]       cmdVec,
  input  logic             msgPending,
  output logic             busy,
  output strobe_t          strb,
  output logic [PIX_W-1:0] selPin
);

  logic             scanning;
  logic [PIX_W-1:0] scanIdx;
  logic [7:0]       eoiVecQ;
  logic             accept;
  logic             isPinOp;
  logic             inRange;
  cmd_op_e          opIn;

  assign opIn    = cmd_op_e'(cmdOp);
  assign busy    = scanning | msgPending;
  assign accept  = cmdValid & ~busy;
  assign inRange = cmdPin < PIN_W'(NUM_PINS);
  assign isPinOp = (opIn == OP_ASSERT) | (opIn == OP_DEASSERT) |
                   (opIn == OP_PULSE)  | (opIn == OP_WRITE);

  always_comb begin
    strb   = '0;
    selPin = cmdPin[PIX_W-1:0];
    if (accept && isPinOp) begin
      strb.op     = opIn;
      strb.pinCmd = inRange;
      strb.badPin = ~inRange;
    end
    if (scanning && !msgPending) begin
      strb.scanStep = 1'b1;
      strb.eoiVec   = eoiVecQ;
      selPin        = scanIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanning <= 1'b0;
      scanIdx  <= '0;
      eoiVecQ  <= '0;
    end else if (accept && opIn == OP_EOI) begin
      scanning <= 1'b1;
      scanIdx  <= '0;
      eoiVecQ  <= cmdVec;
    end else if (strb.scanStep) begin
      if (scanIdx == PIX_W'(NUM_PINS - 1)) scanning <= 1'b0;
      else                                 scanIdx  <= scanIdx + 1'b1;
    end
  end

endmodule

// File: rtl/pin_intr_engine_dp.sv
module pin_intr_engine_dp
  import pin_intr_engine_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  localparam int PIX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [PIX_W-1:0]    selPin,
  input  logic [ENT_W-1:0]    wrData,
  input  logic                msgReady,
  output logic                msgValid,
  output logic [7:0]          msgVector,
  output logic [2:0]          msgDelMode,
  output logic                msgLogical,
  output logic [7:0]          msgDest,
  output logic                msgLevel,
  output logic                tmrUpdate,
  output logic [NUM_PINS-1:0] irrBits,
  output logic                pinErr,
  output logic                cntErr
);

  logic [ENT_W-1:0]        entQ [NUM_PINS];
  logic signed [CNT_W-1:0] cntQ [NUM_PINS];
  logic [NUM_PINS-1:0]     irrQ;

  logic [ENT_W-1:0]        curEnt, newEnt, useEnt;
  logic signed [CNT_W-1:0] curCnt, nextCnt;
  logic                    curIrr;
  logic cntWe, entWe, fire, negErr, irrClr, tmrHit, send, setIrr;

  assign curEnt  = entQ[selPin];
  assign curCnt  = cntQ[selPin];
  assign curIrr  = irrQ[selPin];
  assign newEnt  = wrData & ~RO_BITS;
  assign irrBits = irrQ;

  always_comb begin
    nextCnt = curCnt;
    cntWe   = 1'b0;
    entWe   = 1'b0;
    fire    = 1'b0;
    negErr  = 1'b0;
    irrClr  = 1'b0;
    tmrHit  = 1'b0;
    useEnt  = curEnt;
    if (strb.pinCmd) begin
      unique case (strb.op)
        OP_ASSERT: begin
          nextCnt = curCnt + CNT_W'(1);
          cntWe   = 1'b1;
          fire    = (curCnt == '0);
          negErr  = (nextCnt < 0);
        end
        OP_DEASSERT: begin
          nextCnt = curCnt - CNT_W'(1);
          cntWe   = 1'b1;
          negErr  = (nextCnt < 0);
        end
        OP_PULSE: begin
          fire   = (curCnt == '0);
          negErr = (curCnt < 0);
        end
        OP_WRITE: begin
          entWe  = 1'b1;
          useEnt = newEnt;
          tmrHit = |((curEnt ^ newEnt) & ~NOTMR_BITS);
          fire   = ~curIrr & (curCnt > 0);
        end
        default: ;
      endcase
    end
    if (strb.scanStep && curIrr && curEnt[7:0] == strb.eoiVec) begin
      irrClr = 1'b1;
      fire   = (curCnt > 0);
    end
  end

  assign send   = fire & ~useEnt[MASK_BIT];
  assign setIrr = send & useEnt[LEVEL_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        entQ[i] <= RESET_ENT;
        cntQ[i] <= '0;
      end
      irrQ       <= '0;
      msgValid   <= 1'b0;
      msgVector  <= '0;
      msgDelMode <= '0;
      msgLogical <= 1'b0;
      msgDest    <= '0;
      msgLevel   <= 1'b0;
      tmrUpdate  <= 1'b0;
      pinErr     <= 1'b0;
      cntErr     <= 1'b0;
    end else begin
      tmrUpdate <= tmrHit;
      pinErr    <= strb.badPin;
      cntErr    <= negErr;
      if (cntWe) cntQ[selPin] <= nextCnt;
      if (entWe) entQ[selPin] <= newEnt;
      if (irrClr || setIrr) irrQ[selPin] <= setIrr;
      if (send) begin
        msgValid   <= 1'b1;
        msgVector  <= useEnt[7:0];
        msgDelMode <= useEnt[DMODE_LSB +: 3];
        msgLogical <= useEnt[LOGICAL_BIT];
        msgDest    <= useEnt[DEST_LSB +: 8];
        msgLevel   <= useEnt[LEVEL_BIT];
      end else if (msgReady) begin
        msgValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pin_intr_engine.sv
module pin_intr_engine
  import pin_intr_engine_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  parameter int PIN_W    = $clog2(NUM_PINS) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [PIN_W-1:0]    cmdPin,
  input  logic [63:0]         cmdData,
  output logic                busy,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [7:0]          msgVector,
  output logic [2:0]          msgDelMode,
  output logic                msgLogical,
  output logic [7:0]          msgDest,
  output logic                msgLevel,
  output logic                tmrUpdate,
  output logic [NUM_PINS-1:0] irrBits,
  output logic                pinErr,
  output logic                cntErr
);

  localparam int PIX_W = $clog2(NUM_PINS);

  strobe_t          strb;
  logic [PIX_W-1:0] selPin;

  pin_intr_engine_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdPin     (cmdPin),
    .cmdVec     (cmdData[7:0]),
    .msgPending (msgValid),
    .busy       (busy),
    .strb       (strb),
    .selPin     (selPin)
  );

  pin_intr_engine_dp #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .selPin     (selPin),
    .wrData     (cmdData),
    .msgReady   (msgReady),
    .msgValid   (msgValid),
    .msgVector  (msgVector),
    .msgDelMode (msgDelMode),
    .msgLogical (msgLogical),
    .msgDest    (msgDest),
    .msgLevel   (msgLevel),
    .tmrUpdate  (tmrUpdate),
    .irrBits    (irrBits),
    .pinErr     (pinErr),
    .cntErr     (cntErr)
  );

endmodule

// File: rtl/pin_intr_engine_chk.sv
module pin_intr_engine_chk #(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = $clog2(NUM_PINS) + 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [2:0]          cmdOp,
  input logic [PIN_W-1:0]    cmdPin,
  input logic                busy,
  input logic                msgValid,
  input logic                msgReady,
  input logic [7:0]          msgVector,
  input logic [2:0]          msgDelMode,
  input logic                msgLogical,
  input logic [7:0]          msgDest,
  input logic                msgLevel,
  input logic [NUM_PINS-1:0] irrBits,
  input logic                pinErr
);

  // R10: a waiting message keeps every field until taken
  a_r10_msg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVector) && $stable(msgDest) &&
                                 $stable(msgDelMode) && $stable(msgLogical) && $stable(msgLevel)))
    else $error("a_r10_msg_hold");

  // R10: back-pressure covers a pending message
  a_r10_busy_pending: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> busy)
    else $error("a_r10_busy_pending");

  // R9: the error flag only follows an accepted out-of-range pin command
  a_r9_pinerr_cause: assert property (@(posedge clk) disable iff (!rstN)
    pinErr |-> $past(cmdValid && !busy && cmdPin >= PIN_W'(NUM_PINS) && cmdOp != 3'd3))
    else $error("a_r9_pinerr_cause");

  // R8: an accepted end-of-interrupt starts a scan that holds busy
  a_r8_eoi_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp == 3'd3) |=> busy)
    else $error("a_r8_eoi_busy");

  // R5: a newly set remote IRR comes with a newly issued level message
  a_r5_irr_with_msg: assert property (@(posedge clk) disable iff (!rstN)
    (|(irrBits & ~$past(irrBits))) |-> (msgValid && msgLevel && !$past(msgValid)))
    else $error("a_r5_irr_with_msg");

  // R5: at most one remote IRR rises per cycle
  a_r5_one_irr_rise: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irrBits & ~$past(irrBits)) <= 1)
    else $error("a_r5_one_irr_rise");

endmodule

bind pin_intr_engine pin_intr_engine_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .cmdPin     (cmdPin),
  .busy       (busy),
  .msgValid   (msgValid),
  .msgReady   (msgReady),
  .msgVector  (msgVector),
  .msgDelMode (msgDelMode),
  .msgLogical (msgLogical),
  .msgDest    (msgDest),
  .msgLevel   (msgLevel),
  .irrBits    (irrBits),
  .pinErr     (pinErr)
);

// File: tb/pin_intr_engine_tb.sv
`timescale 1ns/1ps
module pin_intr_engine_tb;

  localparam int NP = 8;
  localparam int CW = 4;
  localparam int PW = 4;

  localparam logic [2:0] A = 3'd0, D = 3'd1, P = 3'd2, E = 3'd3, W = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [PW-1:0] cmdPin = '0;
  logic [63:0] cmdData = '0;
  logic msgReady = 1'b0;
  logic busy, msgValid, msgLogical, msgLevel, tmrUpdate, pinErr, cntErr;
  logic [7:0] msgVector, msgDest;
  logic [2:0] msgDelMode;
  logic [NP-1:0] irrBits;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_intr_engine #(.NUM_PINS(NP), .CNT_W(CW), .PIN_W(PW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPin(cmdPin),
    .cmdData(cmdData), .busy(busy), .msgValid(msgValid), .msgReady(msgReady),
    .msgVector(msgVector), .msgDelMode(msgDelMode), .msgLogical(msgLogical),
    .msgDest(msgDest), .msgLevel(msgLevel), .tmrUpdate(tmrUpdate), .irrBits(irrBits),
    .pinErr(pinErr), .cntErr(cntErr)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  pin;
    logic [63:0] data;
    logic        expMsg;
    logic [7:0]  expVec;
    logic [2:0]  expDm;
    logic        expLog;
    logic [7:0]  expDest;
    logic        expLvl;
    logic        expTmr;
    logic        expCnt;
  } vec_t;

  localparam logic [63:0] E1  = 64'h5A00_0000_0000_0231;
  localparam logic [63:0] E1M = 64'h5A00_0000_0001_2231;

  localparam vec_t TBL [12] = '{
    '{W, 4'd1, E1,  1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{A, 4'd1, 64'd0, 1'b1, 8'h31, 3'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0},
    '{A, 4'd1, 64'd0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{D, 4'd1, 64'd0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{D, 4'd1, 64'd0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{P, 4'd1, 64'd0, 1'b1, 8'h31, 3'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0},
    '{D, 4'd1, 64'd0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    '{P, 4'd1, 64'd0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    '{A, 4'd1, 64'd0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{A, 4'd1, 64'd0, 1'b1, 8'h31, 3'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0},
    '{W, 4'd1, E1M, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{W, 4'd1, E1,  1'b1, 8'h31, 3'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Issue one command at a negedge once busy is low; return at the negedge after acceptance.
  task automatic doCmd(logic [2:0] op, logic [PW-1:0] pin, logic [63:0] data);
    while (busy) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPin = pin; cmdData = data;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic popMsg(string tag, logic [7:0] v, logic [2:0] dm, logic lg, logic [7:0] ds, logic lv);
    check({tag, " msgValid"}, 64'(msgValid), 64'd1);
    check({tag, " vector"},   64'(msgVector), 64'(v));
    check({tag, " delMode"},  64'(msgDelMode), 64'(dm));
    check({tag, " logical"},  64'(msgLogical), 64'(lg));
    check({tag, " dest"},     64'(msgDest), 64'(ds));
    check({tag, " level"},    64'(msgLevel), 64'(lv));
    msgReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msgReady = 1'b0;
    check({tag, " msg taken"}, 64'(msgValid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R11: reset state
    check("R11 reset msgValid", 64'(msgValid), 64'd0);
    check("R11 reset busy", 64'(busy), 64'd0);
    check("R4 reset irrBits", 64'(irrBits), 64'd0);

    // Table walk on pin 1: counts, pulses, negative counts, mask and polarity writes
    for (int i = 0; i < 12; i++) begin
      doCmd(TBL[i].op, TBL[i].pin, TBL[i].data);
      check($sformatf("R2 table[%0d] message", i), 64'(msgValid), 64'(TBL[i].expMsg));
      check($sformatf("R7 table[%0d] tmrUpdate", i), 64'(tmrUpdate), 64'(TBL[i].expTmr));
      check($sformatf("R3 table[%0d] cntErr", i), 64'(cntErr), 64'(TBL[i].expCnt));
      if (TBL[i].expMsg && msgValid)
        popMsg($sformatf("R5 table[%0d]", i), TBL[i].expVec, TBL[i].expDm, TBL[i].expLog,
               TBL[i].expDest, TBL[i].expLvl);
    end

    // R5: level-triggered pin 2, logical, mode 1, vector 44, dest 0F
    doCmd(W, 4'd2, 64'h0F00_0000_0000_8944);
    check("R7 level write tmr", 64'(tmrUpdate), 64'd1);
    doCmd(A, 4'd2, 64'd0);
    popMsg("R5 level send", 8'h44, 3'd1, 1'b1, 8'h0F, 1'b1);
    check("R5 irr set", 64'(irrBits), 64'h04);

    // R6: read-only bits in data ignored; no send while IRR set; R7 no notice
    doCmd(W, 4'd2, 64'h0F00_0000_0000_D944);
    check("R6 write keeps irr", 64'(irrBits), 64'h04);
    check("R6 no send with irr", 64'(msgValid), 64'd0);
    check("R7 unchanged entry no tmr", 64'(tmrUpdate), 64'd0);

    doCmd(W, 4'd3, 64'h0F00_0000_0000_8944);
    doCmd(A, 4'd3, 64'd0);
    popMsg("R5 pin3 send", 8'h44, 3'd1, 1'b1, 8'h0F, 1'b1);
    doCmd(D, 4'd3, 64'd0);
    check("R1 pin3 deassert no msg", 64'(msgValid), 64'd0);
    doCmd(W, 4'd4, 64'h0F00_0000_0000_8955);
    doCmd(A, 4'd4, 64'd0);
    popMsg("R5 pin4 send", 8'h55, 3'd1, 1'b1, 8'h0F, 1'b1);
    check("R5 irr three pins", 64'(irrBits), 64'h1C);

    // R8: end-of-interrupt for vector 44
    doCmd(E, 4'd0, 64'h44);
    check("R8 busy during scan", 64'(busy), 64'd1);
    while (!msgValid && busy) @(negedge clk);
    popMsg("R8 resend pin2", 8'h44, 3'd1, 1'b1, 8'h0F, 1'b1);
    while (busy) @(negedge clk);
    check("R8 no second resend", 64'(msgValid), 64'd0);
    check("R8 irr after scan", 64'(irrBits), 64'h14);

    // R4: masked pin 5 counts but sends nothing; R6 unmask write sends
    doCmd(A, 4'd5, 64'd0);
    check("R4 masked no msg", 64'(msgValid), 64'd0);
    check("R4 masked irr unchanged", 64'(irrBits), 64'h14);
    doCmd(W, 4'd5, 64'h2100_0000_0000_0066);
    check("R7 unmask write tmr", 64'(tmrUpdate), 64'd1);
    popMsg("R6 send on write", 8'h66, 3'd0, 1'b0, 8'h21, 1'b0);

    // R9: out-of-range pins must not alias onto pin 0
    doCmd(W, 4'd0, 64'h0100_0000_0000_0010);
    doCmd(A, 4'd8, 64'd0);
    check("R9 pinErr idx 8", 64'(pinErr), 64'd1);
    check("R9 no msg idx 8", 64'(msgValid), 64'd0);
    doCmd(A, 4'd15, 64'd0);
    check("R9 pinErr idx 15", 64'(pinErr), 64'd1);
    doCmd(A, 4'd0, 64'd0);
    check("R9 pin0 count untouched", 64'(pinErr), 64'd0);
    popMsg("R9 pin0 send", 8'h10, 3'd0, 1'b0, 8'h01, 1'b0);

    // R10: pending message holds and blocks commands
    doCmd(D, 4'd0, 64'd0);
    doCmd(A, 4'd0, 64'd0);
    cmdValid = 1'b1; cmdOp = D; cmdPin = 4'd5; cmdData = '0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10 held valid", 64'(msgValid), 64'd1);
      check("R10 held vector", 64'(msgVector), 64'h10);
      check("R10 busy", 64'(busy), 64'd1);
    end
    cmdValid = 1'b0;
    popMsg("R10 held send", 8'h10, 3'd0, 1'b0, 8'h01, 1'b0);
    doCmd(A, 4'd5, 64'd0);
    check("R10 blocked deassert ignored", 64'(msgValid), 64'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule